// File: doc/BRIEF.md
# GPIO Interrupt Style Detector

This block watches a bank of general-purpose input pins and keeps one pending-interrupt bit per pin. Each pin is given a three-bit trigger style: a level that is high, a level that is low, a rising edge, a falling edge, or any change. The pending bits drive the interrupt output directly, one wire per pin, so a downstream controller sees a pin's request for as long as its bit is set.

Software sets the styles and clears pending bits through a simple write port. The style fields are split across two style registers of eight pins each. The pending register is cleared by writing ones to it. A pending bit for a level style cannot be cleared while the level is still present, because it sets again on the same edge. The documented way to change a pin's style is to disable its field, clear its pending bit, and then write the new code.

Every pin passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with the value it had one cycle earlier.

Top module: `gpio_irq_style`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released with all pins low, `irq_o` is all zero.
- R2: The write address selects the target. Address 0 holds the style fields for pins 0–7, with pin k at data bits [3k+2:3k]. Address 1 holds the style fields for pins 8–15, with pin k at bits [3(k-8)+2:3(k-8)]. Address 2 is the pending register, one bit per pin at bit k. A write to address 3 changes nothing.
- R3: Style code 0 (level high) sets a pin's pending bit on every cycle in which its synchronized input is 1.
- R4: Style code 1 (level low) sets a pin's pending bit on every cycle in which its synchronized input is 0.
- R5: Style code 2 (rising) sets the pending bit only when the synchronized input goes from 0 to 1.
- R6: Style code 3 (falling) sets the pending bit only when the synchronized input goes from 1 to 0.
- R7: Style code 4 (any change) sets the pending bit on both a 0-to-1 and a 1-to-0 change.
- R8: Style codes 5, 6 and 7 disable detection. A pending bit with such a style never becomes set, and it keeps its value until it is cleared.
- R9: Writing 1 to a bit of the pending register clears that bit. Writing 0 leaves it as it was. Once set, a pending bit stays set until it is cleared by such a write.
- R10: A clear of a level-style pending bit has no effect while the level condition still holds. The bit clears normally once the condition is gone.
- R11: When a clear and a new detection of the same pin fall on the same clock edge, the detection wins and the bit stays 1.
- R12: A pin change that is set up before clock edge N appears on `irq_o` right after edge N+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (2) | Write address (0/1 style banks, 2 pending register) |
| wr_data | input | DATA_W (24) | Write data |
| irq_o | output | NUM_PINS | Pending bits, one interrupt per pin |

## Verification
The assertions take the synchronized pin values and the style fields as given, and judge each pending bit one edge later. This assumes the pins change only relative to the clock, with no glitch that is shorter than a cycle. The bench drives pins and writes only on the falling clock edge, keeps each level steady for at least three edges, and keeps all pins low through reset. Because of that, every edge the synchronizer records is a clean, single transition. The sweep covers every pin with every style code.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int STYLE_W = 3;

    localparam logic [STYLE_W-1:0] STY_HIGH = 3'd0;
    localparam logic [STYLE_W-1:0] STY_LOW  = 3'd1;
    localparam logic [STYLE_W-1:0] STY_RISE = 3'd2;
    localparam logic [STYLE_W-1:0] STY_FALL = 3'd3;
    localparam logic [STYLE_W-1:0] STY_BOTH = 3'd4;

    // Detection rule for one pin: cur is the synchronized level, prev the level one cycle earlier.
    function automatic logic style_hit(logic [STYLE_W-1:0] sty, logic cur, logic prev);
        case (sty)
            STY_HIGH: return cur;
            STY_LOW:  return ~cur;
            STY_RISE: return cur & ~prev;
            STY_FALL: return ~cur & prev;
            STY_BOTH: return cur ^ prev;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = pin_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.chain[k] = s_q.chain[k-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_o  = s_q.chain[STAGES-1];
    assign prev_o = s_q.prev;

endmodule

// File: rtl/gpio_irq_style_bank.sv
module gpio_irq_style_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS     = 16,
    parameter int PINS_PER_REG = 8,
    parameter int ADDR_W       = 2,
    parameter int FIELD_BITS   = PINS_PER_REG * STYLE_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [FIELD_BITS-1:0]            wr_data,
    output logic [NUM_PINS-1:0][STYLE_W-1:0] style_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0][STYLE_W-1:0] style;
    } bank_t;

    bank_t b_d, b_q;

    logic [NUM_PINS-1:0]              sel;
    logic [NUM_PINS-1:0][STYLE_W-1:0] field;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BANK = p / PINS_PER_REG;
        localparam int SLOT = p % PINS_PER_REG;
        assign sel[p]   = wr_en && (wr_addr == ADDR_W'(BANK));
        assign field[p] = wr_data[SLOT*STYLE_W +: STYLE_W];
    end

    always_comb begin
        b_d = b_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (sel[p]) b_d.style[p] = field[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign style_o = b_q.style;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic [NUM_PINS-1:0][STYLE_W-1:0] style_i,
    input  logic [NUM_PINS-1:0]              cur_i,
    input  logic [NUM_PINS-1:0]              prev_i,
    output logic [NUM_PINS-1:0]              hit_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_det
        assign hit_o[p] = style_hit(style_i[p], cur_i[p], prev_i[p]);
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NUM_PINS    = 16,
    parameter int ADDR_W      = 2,
    parameter int STATUS_ADDR = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    input  logic [NUM_PINS-1:0] hit_i,
    output logic [NUM_PINS-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] pend;
    } stat_t;

    stat_t st_d, st_q;
    logic [NUM_PINS-1:0] clr;

    always_comb begin
        clr = '0;
        if (wr_en && (wr_addr == ADDR_W'(STATUS_ADDR))) clr = wr_data;
        st_d      = st_q;
        // a fresh detection outranks a clear in the same cycle
        st_d.pend = hit_i | (st_q.pend & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/gpio_irq_style.sv
module gpio_irq_style
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS     = 16,
    parameter int PINS_PER_REG = 8,
    parameter int SYNC_STAGES  = 2,
    localparam int NUM_REGS    = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG,
    localparam int ADDR_W      = $clog2(NUM_REGS + 1),
    localparam int DATA_W      = (PINS_PER_REG * STYLE_W > NUM_PINS) ?
                                 PINS_PER_REG * STYLE_W : NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] irq_o
);

    localparam int FIELD_BITS = PINS_PER_REG * STYLE_W;

    logic [NUM_PINS-1:0]              pin_sync;
    logic [NUM_PINS-1:0]              pin_prev;
    logic [NUM_PINS-1:0][STYLE_W-1:0] style_cfg;
    logic [NUM_PINS-1:0]              hit;

    gpio_irq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cur_o  (pin_sync),
        .prev_o (pin_prev)
    );

    gpio_irq_style_bank #(
        .NUM_PINS     (NUM_PINS),
        .PINS_PER_REG (PINS_PER_REG),
        .ADDR_W       (ADDR_W),
        .FIELD_BITS   (FIELD_BITS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data[FIELD_BITS-1:0]),
        .style_o (style_cfg)
    );

    gpio_irq_detect #(
        .NUM_PINS (NUM_PINS)
    ) u_det (
        .style_i (style_cfg),
        .cur_i   (pin_sync),
        .prev_i  (pin_prev),
        .hit_o   (hit)
    );

    gpio_irq_status #(
        .NUM_PINS    (NUM_PINS),
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (NUM_REGS)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data[NUM_PINS-1:0]),
        .hit_i   (hit),
        .pend_o  (irq_o)
    );

endmodule

// File: rtl/gpio_irq_style_chk.sv
module gpio_irq_style_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 2,
    parameter int STAT_ADR = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                wr_addr,
    input logic [NUM_PINS-1:0]              wr_data,
    input logic [NUM_PINS-1:0]              irq_o,
    input logic [NUM_PINS-1:0]              pin_sync,
    input logic [NUM_PINS-1:0]              pin_prev,
    input logic [NUM_PINS-1:0][STYLE_W-1:0] style_cfg
);

    logic [NUM_PINS-1:0] clr_mask;
    assign clr_mask = (wr_en && wr_addr == ADDR_W'(STAT_ADR)) ? wr_data : '0;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> irq_o == '0);

    // R9
    sticky_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(irq_o) & ~$past(clr_mask) & ~irq_o) == '0));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // R3
        level_high_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (style_cfg[i] == STY_HIGH && pin_sync[i]) |=> irq_o[i]);
        // R10
        level_low_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (style_cfg[i] == STY_LOW && !pin_sync[i]) |=> irq_o[i]);
        // R11
        rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (style_cfg[i] == STY_RISE && pin_sync[i] && !pin_prev[i]) |=> irq_o[i]);
        // R6
        fall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (style_cfg[i] == STY_FALL && !pin_sync[i] && pin_prev[i]) |=> irq_o[i]);
        // R8
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (style_cfg[i] > STY_BOTH && !irq_o[i]) |=> !irq_o[i]);
    end

endmodule

bind gpio_irq_style gpio_irq_style_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .STAT_ADR (NUM_REGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data[NUM_PINS-1:0]),
    .irq_o     (irq_o),
    .pin_sync  (pin_sync),
    .pin_prev  (pin_prev),
    .style_cfg (style_cfg)
);

// File: tb/gpio_irq_style_tb.sv
module gpio_irq_style_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pins;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [23:0] wr_data;
    logic [15:0] irq;

    int n_vec  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_irq_style u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pins),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq_o   (irq)
    );

    task automatic check(input string tag, input logic [15:0] exp);
        n_vec++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%h expected=%h", tag, irq, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [23:0] style_word(input int slot, input int code);
        logic [23:0] w = 24'hFF_FFFF;
        w[slot*3 +: 3] = 3'(code);
        return w;
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic disable_all();
        wr(2'd0, 24'hFF_FFFF);
        wr(2'd1, 24'hFF_FFFF);
        wr(2'd2, 24'h00_FFFF);
    endtask

    initial begin
        rst_n   = 1'b0;
        pins    = '0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 16'h0);

        // sweep: every pin with every style code
        for (int pin = 0; pin < 16; pin++) begin
            for (int code = 0; code < 8; code++) begin
                logic [15:0] b;
                logic [15:0] e;
                b = 16'(1) << pin;
                disable_all();
                wr(2'(pin / 8), style_word(pin % 8, code));   // R2 bank and slot position
                wr(2'd2, 24'(b));
                settle();
                e = (code == 1) ? b : 16'h0;
                check(tag_of(code), e);

                pins[pin] = 1'b1;
                settle();
                if (code == 0 || code == 2 || code == 4) e = e | b;
                check(tag_of(code), e);

                wr(2'd2, 24'(b));                              // R10 level high holds
                e = (code == 0) ? b : 16'h0;
                check((code == 0) ? "R10" : "R9", e);

                pins[pin] = 1'b0;
                settle();
                if (code == 1 || code == 3 || code == 4) e = e | b;
                check(tag_of(code), e);

                wr(2'd2, 24'(b));
                e = (code == 1) ? b : 16'h0;
                check((code == 1) ? "R10" : "R9", e);
            end
        end

        // R12 latency: visible after the third edge, not earlier
        disable_all();
        wr(2'd0, style_word(3, 2));
        pins[3] = 1'b1;
        repeat (2) @(negedge clk);
        check("R12 early", 16'h0);
        @(negedge clk);
        check("R12 on time", 16'h0008);

        // R2: address 3 is ignored
        wr(2'd3, 24'hFF_FFFF);
        check("R2 addr3", 16'h0008);
        pins[3] = 1'b0;
        settle();
        check("R2 addr3 style kept", 16'h0008);

        // R9 partial clear, R2 second bank position
        disable_all();
        wr(2'd0, style_word(5, 2));
        wr(2'd1, style_word(1, 2));
        pins[5] = 1'b1;
        pins[9] = 1'b1;
        settle();
        check("R2 R5 two pins", 16'h0220);
        wr(2'd2, 24'h00_0200);
        check("R9 partial clear", 16'h0020);
        pins[5] = 1'b0;
        settle();
        check("R5 falling ignored", 16'h0020);

        // R11: clear lands on the same edge as a new rise
        pins[5] = 1'b1;
        repeat (2) @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'd2;
        wr_data = 24'h00_0020;
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 set beats clear", 16'h0020);
        wr(2'd2, 24'h00_0020);
        check("R9 clear after", 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule